// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block runs 12-bit successive-approximation conversions on one of three analog inputs. Software reaches it over a simple word-addressed register bus. It turns the converter on and selects an input through a control word. It sets the conversion timing through a cycle word. It then either polls a busy flag or waits for a level interrupt, and finally reads a per-input result word whose top flag says whether the code is fresh.

On the analog side the block drives a one-hot input-mux select and a 12-bit trial code for the DAC, and it samples a single comparator bit. Each conversion runs three phases in order:

- a startup phase;
- a sample window;
- twelve compare slots, most significant bit first.

Each phase lasts a programmable number of ticks of a divided conversion clock. A full-scale code of 4095 corresponds to just under 3300 mV, so one LSB is 3300/4096 mV.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, these offsets read zero: control (0x04), status (0x08), interrupt enable (0x20), pending (0x28) and every result word. The cycle word at 0x0C reads 0x000F1F0F. irq_o is low, ch_sel_o is zero and dac_code_o is zero.
- R2: A conversion starts on a bus write to 0x04 only when all of the following hold: bit 0 (enable) is 1, exactly one of bits 7:5 is set (bit 5+n selects input n), and the enable bit already stored is 0. A write with the enable already stored, with two select bits or with no select bit starts nothing.
- R3: Status bit 0 at 0x08 (busy) goes high in the cycle after the starting write. It stays high for exactly (D+1)*((S+1)+(W+1)+12*(C+1)) clock cycles, where S, W, D and C are the cycle-word fields latched at the start.
- R4: The cycle word at 0x0C holds the startup count S in bits 4:0, the window W in bits 11:8, the divider D in bits 15:12 and the compare count C in bits 19:16. All other bits are read-only zero.
- R5: The approximation decides bits from bit 11 down to bit 0. It keeps a trial bit when cmp_i is 1 at the end of that bit's compare slot. With a comparator that reports input >= dac_code_o, the stored code equals the input level, including codes 0 and 4095.
- R6: The result word for input n is at 0x14+4*n, with the code in bits 11:0 and a valid flag in bit 15. A start clears that input's word. Completion writes the code with valid set. The words of the other inputs are unchanged.
- R7: Completion sets the pending flag, read at 0x28 bit 0. Writing 1 to 0x24 bit 0 clears it, writing 0 there has no effect, and a completion in the same cycle as a clear wins.
- R8: irq_o is high exactly while pending is set and the enable at 0x20 bit 0 is 1.
- R9: A write to 0x04 with bit 0 clear during a conversion aborts it. Busy drops the next cycle, pending is not set, and the aborted input's result word reads zero.
- R10: Reads of offsets that hold no register return zero.
- R11: While busy, ch_sel_o is the one-hot select of the converting input. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on the offset |
| irq_o | output | 1 | Level completion interrupt |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC level |
| dac_code_o | output | 12 | Trial code for the DAC |
| ch_sel_o | output | 3 | One-hot analog input select |

## Verification
The bench goes after the exact busy length under two different timing words. A controller that miscounts the divider or adds a phase edge keeps ch_sel_o high a cycle too long or too short, and the per-clock comparison catches it. It converts inputs at 0, 4095 and a mixed pattern. Bit-ordering or off-by-one decision errors then produce wrong codes, most visibly at the rails. It also drives the start qualifiers that must not start anything: re-enable without a zero write, two selects, and no select. A design that starts anyway raises ch_sel_o. Finally it aborts mid-conversion. An abort that still completed would set pending and a valid result, and an interrupt gated wrongly by the enable would toggle irq_o against the model.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STARTUP = 2'd1,
    ST_SAMPLE  = 2'd2,
    ST_CONVERT = 2'd3
  } sar_state_e;

  typedef struct packed {
    logic [4:0] startup;
    logic [3:0] window;
    logic [3:0] div;
    logic [3:0] cmp;
  } sar_timing_t;

  localparam int OFS_CTRL   = 'h04;
  localparam int OFS_STAT   = 'h08;
  localparam int OFS_CYC    = 'h0C;
  localparam int OFS_RES0   = 'h14;
  localparam int OFS_IEN    = 'h20;
  localparam int OFS_ICLR   = 'h24;
  localparam int OFS_IPEND  = 'h28;

  localparam int SEL_LSB    = 5;
  localparam int VLD_BIT    = 15;

  localparam sar_timing_t TIMING_RST = '{startup: 5'h0F, window: 4'hF, div: 4'h1, cmp: 4'hF};

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)              cnt_d = '0;
    else if (cnt_q == div_i) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == div_i);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i && (div_i != '0)) |=> !tick_o);

endmodule

// File: rtl/sar_approx_seq.sv
module sar_approx_seq
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  sar_timing_t      timing_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [3:0]       div_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [RES_W-1:0] dac_o,
  output logic             done_o,
  output logic [RES_W-1:0] done_code_o
);

  localparam int BIT_W = $clog2(RES_W);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(RES_W - 1);

  sar_state_e       state_q, state_d;
  logic [4:0]       pcnt_q, pcnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [RES_W-1:0] code_q, code_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  sar_timing_t      tim_q, tim_d;
  logic [RES_W-1:0] trial, decided;
  logic             slot_end;

  assign trial    = code_q | (RES_W'(1) << bit_q);
  assign decided  = cmp_i ? trial : code_q;
  assign slot_end = tick_i && (pcnt_q == {1'b0, tim_q.cmp});

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    bit_d   = bit_q;
    code_d  = code_q;
    ch_d    = ch_q;
    tim_d   = tim_q;
    done_o  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_d = ST_STARTUP;
            pcnt_d  = '0;
            code_d  = '0;
            ch_d    = start_ch_i;
            tim_d   = timing_i;
          end
        end
        ST_STARTUP: begin
          if (tick_i) begin
            if (pcnt_q == tim_q.startup) begin
              state_d = ST_SAMPLE;
              pcnt_d  = '0;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
            end
          end
        end
        ST_SAMPLE: begin
          if (tick_i) begin
            if (pcnt_q == {1'b0, tim_q.window}) begin
              state_d = ST_CONVERT;
              pcnt_d  = '0;
              bit_d   = TOP_BIT;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
            end
          end
        end
        ST_CONVERT: begin
          if (slot_end) begin
            code_d = decided;
            pcnt_d = '0;
            if (bit_q == '0) begin
              state_d = ST_IDLE;
              done_o  = 1'b1;
            end else begin
              bit_d = bit_q - 1'b1;
            end
          end else if (tick_i) begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      bit_q   <= '0;
      code_q  <= '0;
      ch_q    <= '0;
      tim_q   <= TIMING_RST;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      bit_q   <= bit_d;
      code_q  <= code_d;
      ch_q    <= ch_d;
      tim_q   <= tim_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign div_o       = tim_q.div;
  assign ch_o        = ch_q;
  assign dac_o       = (state_q == ST_CONVERT) ? trial : '0;
  assign done_code_o = decided;

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == ST_IDLE));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (state_q == ST_IDLE));

  // R5
  trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONVERT) |-> ($countones(dac_o & ~code_q) == 1));

endmodule

// File: rtl/sar_reg_file.sv
module sar_reg_file
  import sar_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 12,
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [CH_W-1:0]   done_ch_i,
  input  logic [RES_W-1:0]  done_code_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [CH_W-1:0]   start_ch_o,
  output sar_timing_t       timing_o,
  output logic              irq_o
);

  logic              en_q, en_d;
  logic [NUM_CH-1:0] sel_q, sel_d;
  sar_timing_t       tim_q, tim_d;
  logic              ien_q, ien_d;
  logic              pend_q, pend_d;
  logic [RES_W-1:0]  res_code_q [NUM_CH];
  logic [NUM_CH-1:0] res_vld_q;

  logic              wr_en, wr_ctrl;
  logic [NUM_CH-1:0] new_sel;

  assign wr_en   = bus_sel_i && bus_wr_i;
  assign wr_ctrl = wr_en && (bus_addr_i == ADDR_W'(OFS_CTRL));
  assign new_sel = bus_wdata_i[SEL_LSB +: NUM_CH];

  assign start_o = wr_ctrl && bus_wdata_i[0] && $onehot(new_sel) && !en_q;
  assign abort_o = wr_ctrl && !bus_wdata_i[0] && busy_i;

  always_comb begin
    start_ch_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (new_sel[i]) start_ch_o = CH_W'(i);
    end
  end

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    tim_d  = tim_q;
    ien_d  = ien_q;
    pend_d = pend_q;
    if (wr_ctrl) begin
      en_d  = bus_wdata_i[0];
      sel_d = new_sel;
    end
    if (wr_en && (bus_addr_i == ADDR_W'(OFS_CYC))) begin
      tim_d.startup = bus_wdata_i[4:0];
      tim_d.window  = bus_wdata_i[11:8];
      tim_d.div     = bus_wdata_i[15:12];
      tim_d.cmp     = bus_wdata_i[19:16];
    end
    if (wr_en && (bus_addr_i == ADDR_W'(OFS_IEN))) ien_d = bus_wdata_i[0];
    if (wr_en && (bus_addr_i == ADDR_W'(OFS_ICLR)) && bus_wdata_i[0]) pend_d = 1'b0;
    if (done_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      tim_q  <= TIMING_RST;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      tim_q  <= tim_d;
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    logic             clr, set;
    logic [RES_W-1:0] code_d;
    logic             vld_d;
    assign clr = start_o && (start_ch_o == CH_W'(g));
    assign set = done_i && (done_ch_i == CH_W'(g));
    always_comb begin
      code_d = res_code_q[g];
      vld_d  = res_vld_q[g];
      if (clr) begin
        code_d = '0;
        vld_d  = 1'b0;
      end else if (set) begin
        code_d = done_code_i;
        vld_d  = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_code_q[g] <= '0;
        res_vld_q[g]  <= 1'b0;
      end else begin
        res_code_q[g] <= code_d;
        res_vld_q[g]  <= vld_d;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_CTRL)) begin
      bus_rdata_o[0]                 = en_q;
      bus_rdata_o[SEL_LSB +: NUM_CH] = sel_q;
    end
    if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o[0] = busy_i;
    if (bus_addr_i == ADDR_W'(OFS_CYC)) begin
      bus_rdata_o[4:0]   = tim_q.startup;
      bus_rdata_o[11:8]  = tim_q.window;
      bus_rdata_o[15:12] = tim_q.div;
      bus_rdata_o[19:16] = tim_q.cmp;
    end
    if (bus_addr_i == ADDR_W'(OFS_IEN))   bus_rdata_o[0] = ien_q;
    if (bus_addr_i == ADDR_W'(OFS_IPEND)) bus_rdata_o[0] = pend_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr_i == ADDR_W'(OFS_RES0 + 4 * i)) begin
        bus_rdata_o[RES_W-1:0] = res_code_q[i];
        bus_rdata_o[VLD_BIT]   = res_vld_q[i];
      end
    end
  end

  assign timing_o = tim_q;
  assign irq_o    = pend_q && ien_q;

  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> pend_q);

  // R6
  res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> res_vld_q[$past(done_ch_i)]);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !done_i);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 12,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [NUM_CH-1:0] ch_sel_o
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic             start_w, abort_w, busy_w, done_w, tick_w;
  logic [CH_W-1:0]  start_ch_w, ch_w;
  logic [RES_W-1:0] done_code_w;
  logic [3:0]       div_w;
  sar_timing_t      timing_w;

  sar_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W), .NUM_CH(NUM_CH), .CH_W(CH_W)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy_w),
    .done_i      (done_w),
    .done_ch_i   (ch_w),
    .done_code_i (done_code_w),
    .start_o     (start_w),
    .abort_o     (abort_w),
    .start_ch_o  (start_ch_w),
    .timing_o    (timing_w),
    .irq_o       (irq_o)
  );

  sar_tick_gen #(.DIV_W(4)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_w),
    .div_i  (div_w),
    .tick_o (tick_w)
  );

  sar_approx_seq #(.RES_W(RES_W), .CH_W(CH_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .abort_i     (abort_w),
    .start_ch_i  (start_ch_w),
    .timing_i    (timing_w),
    .tick_i      (tick_w),
    .cmp_i       (cmp_i),
    .busy_o      (busy_w),
    .div_o       (div_w),
    .ch_o        (ch_w),
    .dac_o       (dac_code_o),
    .done_o      (done_w),
    .done_code_o (done_code_w)
  );

  assign ch_sel_o = busy_w ? (NUM_CH'(1) << ch_w) : '0;

  // R11
  mux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel_o));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_w) |-> $past(done_w || abort_w));

  // R1
  idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (dac_code_o == '0));

endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        b_sel, b_wr;
  logic [7:0]  b_addr;
  logic [31:0] b_wdata, b_rdata;
  logic        irq, cmp;
  logic [11:0] dac, vin;
  logic [2:0]  mux;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_chk = 0;

  sar_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(b_sel), .bus_wr_i(b_wr),
    .bus_addr_i(b_addr), .bus_wdata_i(b_wdata), .bus_rdata_o(b_rdata),
    .irq_o(irq), .cmp_i(cmp), .dac_code_o(dac), .ch_sel_o(mux)
  );

  assign cmp = (vin >= dac);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model state
  int          m_left;
  int          m_ch;
  bit          m_en, m_pend, m_ien;
  logic [31:0] m_cyc;
  logic [31:0] m_res [3];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_ch = 0; m_en = 0; m_pend = 0; m_ien = 0;
      m_cyc = 32'h000F1F0F;
      for (int i = 0; i < 3; i++) m_res[i] = 32'h0;
    end else begin
      bit fin;
      fin = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_res[m_ch] = 32'h8000 | {20'h0, vin};
          m_pend = 1;
          fin = 1;
        end
      end
      if (b_sel && b_wr) begin
        case (b_addr)
          8'h04: begin
            if (b_wdata[0] && $countones(b_wdata[7:5]) == 1 && !m_en) begin
              int s, w, d, c;
              s = int'(m_cyc[4:0]); w = int'(m_cyc[11:8]);
              d = int'(m_cyc[15:12]); c = int'(m_cyc[19:16]);
              m_ch = b_wdata[5] ? 0 : (b_wdata[6] ? 1 : 2);
              m_left = (d + 1) * ((s + 1) + (w + 1) + 12 * (c + 1));
              m_res[m_ch] = 32'h0;
            end
            if (!b_wdata[0]) m_left = 0;
            m_en = b_wdata[0];
          end
          8'h0C: m_cyc = b_wdata & 32'h000FFF1F;
          8'h20: m_ien = b_wdata[0];
          8'h24: if (b_wdata[0] && !fin) m_pend = 0;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run_chk) begin
      chk("R11", {29'h0, mux}, (m_left > 0) ? (32'h1 << m_ch) : 32'h0);
      chk("R8", {31'h0, irq}, {31'h0, (m_pend && m_ien)});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d;
    @(posedge clk);
    @(negedge clk);
    b_sel = 0; b_wr = 0; b_wdata = 32'h0;
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [31:0] exp);
    b_addr = a;
    #1;
    chk(tag, b_rdata, exp);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_left > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic convert(int ch, logic [11:0] level);
    vin = level;
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h1 | (32'h20 << ch));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; b_sel = 0; b_wr = 0; b_addr = 8'h0; b_wdata = 32'h0; vin = 12'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run_chk = 1;

    // R1 reset state
    rd(8'h04, "R1", 32'h0);
    rd(8'h08, "R1", 32'h0);
    rd(8'h0C, "R1", 32'h000F1F0F);
    rd(8'h20, "R1", 32'h0);
    rd(8'h28, "R1", 32'h0);
    for (int i = 0; i < 3; i++) rd(8'h14 + 8'(4 * i), "R1", 32'h0);
    chk("R1", {20'h0, dac}, 32'h0);
    // R10 unmapped offsets
    rd(8'h00, "R10", 32'h0);
    rd(8'h10, "R10", 32'h0);
    rd(8'h2C, "R10", 32'h0);
    rd(8'hFC, "R10", 32'h0);

    // R4 field layout
    wr(8'h0C, 32'hFFFFFFFF);
    rd(8'h0C, "R4", 32'h000FFF1F);
    wr(8'h0C, 32'h0);
    rd(8'h0C, "R4", 32'h0);

    // R5 R6 R3 mixed pattern on input 0, fastest timing
    wr(8'h20, 32'h1);
    convert(0, 12'hA5C);
    rd(8'h08, "R3", 32'h1);
    wait_idle();
    rd(8'h08, "R3", 32'h0);
    rd(8'h14, "R5", m_res[0]);
    chk("R5", m_res[0], 32'h8A5C);
    rd(8'h28, "R7", 32'h1);

    // R7 writing zero does not clear, writing one does
    wr(8'h24, 32'h0);
    rd(8'h28, "R7", 32'h1);
    wr(8'h24, 32'h1);
    rd(8'h28, "R7", 32'h0);

    // R3 R5 full scale on input 2 with divider and longer phases
    wr(8'h0C, 32'h0001_2203);
    convert(2, 12'hFFF);
    wait_idle();
    rd(8'h1C, "R5", 32'h8FFF);
    rd(8'h14, "R6", 32'h8A5C);
    wr(8'h24, 32'h1);

    // R5 zero on input 1
    convert(1, 12'h000);
    wait_idle();
    rd(8'h18, "R5", 32'h8000);
    rd(8'h1C, "R6", 32'h8FFF);

    // R2 qualifiers that must not start (mux compared every clock)
    wr(8'h24, 32'h1);
    wr(8'h04, 32'h41);
    repeat (4) @(negedge clk);
    chk("R2", {29'h0, mux}, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h61);
    repeat (4) @(negedge clk);
    chk("R2", {29'h0, mux}, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h01);
    repeat (4) @(negedge clk);
    chk("R2", {29'h0, mux}, 32'h0);
    rd(8'h28, "R2", 32'h0);

    // R9 abort in the middle of a conversion
    wr(8'h0C, 32'h0003_1404);
    convert(1, 12'h07B);
    repeat (20) @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h08, "R9", 32'h0);
    repeat (5) @(negedge clk);
    rd(8'h18, "R9", 32'h0);
    rd(8'h28, "R9", 32'h0);

    // R8 interrupt gated by enable
    wr(8'h0C, 32'h0);
    wr(8'h20, 32'h0);
    convert(0, 12'h3C1);
    wait_idle();
    chk("R8", {31'h0, irq}, 32'h0);
    rd(8'h14, "R6", 32'h83C1);
    wr(8'h20, 32'h1);
    chk("R8", {31'h0, irq}, 32'h1);
    wr(8'h24, 32'h1);
    chk("R8", {31'h0, irq}, 32'h0);

    run_chk = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule